// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Detector

This block decides, from two sampled pulse trains, whether a divided oscillator signal runs ahead of or behind a reference. Both inputs are synchronous samples taken on a fast system clock. Only their rising edges count. Each rising edge sets its own holding flop: `ref_in` sets the up flop and `fb_in` sets the down flop. Once both flops are set they stay set together for a short fixed number of clocks and are then cleared. That clearing delay fixes the width of the narrow pulses the block emits at lock.

The block drives two kinds of output from the same pair of flops.

- **Loop-filter drive.** This is a three-state drive for a charge-pump filter. It is modelled as `pump_up`, `pump_dn` and an enable, `drive_en`. The enable is low, standing for high impedance, whenever neither pump is active.
- **Comparator pulses.** This is a pair of active-low pulses, `phi_r_n` and `phi_v_n`. Each pulse lasts as long as its flop is set, so both go low together for a brief moment on every comparison.

A lock flag rises after a run of consecutive comparisons whose edges arrived close together. It falls on the first comparison that misses.

Top module: `pfd_edge`

## Requirements
- R1: Only a rising edge (sample 1 after sample 0) of `ref_in` or `fb_in` starts a comparison. The output counts per comparison do not depend on how long either input stays high. A flop sets in the cycle after the input's first high sample.
- R2: If the `fb_in` edge comes d cycles after the `ref_in` edge, `pump_up` is high for exactly d cycles per comparison and `pump_dn` stays low.
- R3: If the `fb_in` edge comes d cycles before the `ref_in` edge, `pump_dn` is high for exactly d cycles per comparison and `pump_up` stays low.
- R4: If both rising edges fall in the same cycle, `pump_up`, `pump_dn` and `drive_en` all stay low.
- R5: `drive_en` is high exactly when one of `pump_up` or `pump_dn` is high. The two pumps are never high together.
- R6: If fb leads by d cycles, `phi_v_n` is low for d+CLR_DLY cycles per comparison and `phi_r_n` is low for CLR_DLY cycles (default CLR_DLY=2).
- R7: If fb lags by d cycles, `phi_r_n` is low for d+CLR_DLY cycles per comparison and `phi_v_n` is low for CLR_DLY cycles.
- R8: With coincident edges, `phi_r_n` and `phi_v_n` go low together for CLR_DLY cycles and are never at different levels.
- R9: `lock` rises at the LOCK_N-th consecutive comparison (default 4) whose two edges are at most LOCK_WIN cycles apart (default 1). Before that comparison it stays low.
- R10: `lock` falls at the first comparison whose edges are more than LOCK_WIN cycles apart.
- R11: While `rst_n` is low: both pumps, `drive_en` and `lock` are 0, and both `phi_*_n` outputs are 1.
- R12: If `fb_in` has a higher rising-edge rate than `ref_in`, `pump_dn` is high for more cycles in total than `pump_up`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Sampled reference pulse train |
| fb_in | input | 1 | Sampled divided-oscillator pulse train |
| pump_up | output | 1 | Drive-high request (fb lags) |
| pump_dn | output | 1 | Drive-low request (fb leads) |
| drive_en | output | 1 | Drive enable; low means high impedance |
| phi_r_n | output | 1 | Active-low reference-side comparator pulse |
| phi_v_n | output | 1 | Active-low feedback-side comparator pulse |
| lock | output | 1 | Loop lock indication |

## Verification
The bench measures per-comparison pulse widths in steady state for a lagging, a leading and an aligned feedback train.

- **Off-by-one errors.** A design that clears one cycle early or late would show the wrong `phi_*_n` widths.
- **Missing pump gating.** A design that never gates the pumps on both flops would leak a drive pulse at perfect alignment.

The lock flag is sampled between the third and fourth close comparisons, which catches a counter that trips one comparison early. The bench then injects a single wide gap to show the flag drops at once rather than decaying.

Two further runs probe other faults. The first changes only the input duty cycles; a level-sensitive set would then change the pump counts. The second feeds in a faster feedback train, which must produce net down drive.

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int CLR_DLY  = 2,
  parameter int LOCK_N   = 4,
  parameter int LOCK_WIN = 1,
  parameter int GAP_W    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic pump_up,
  output logic pump_dn,
  output logic drive_en,
  output logic phi_r_n,
  output logic phi_v_n,
  output logic lock
);
  localparam int CLR_W = $clog2(CLR_DLY + 1);
  localparam int LK_W  = $clog2(LOCK_N + 1);

  logic             ref_d, fb_d, up_q, dn_q;
  logic [CLR_W-1:0] clr_cnt;
  logic [GAP_W-1:0] gap;
  logic [LK_W-1:0]  hits;

  logic ref_rise, fb_rise, both, clr, match;
  assign ref_rise = ref_in & ~ref_d;
  assign fb_rise  = fb_in & ~fb_d;
  assign both     = up_q & dn_q;
  assign clr      = both && (clr_cnt == CLR_W'(CLR_DLY - 1));
  assign match    = gap <= GAP_W'(LOCK_WIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_d   <= 1'b0;
      fb_d    <= 1'b0;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      clr_cnt <= '0;
      gap     <= '0;
      hits    <= '0;
    end else begin
      ref_d   <= ref_in;
      fb_d    <= fb_in;
      up_q    <= clr ? ref_rise : (up_q | ref_rise);
      dn_q    <= clr ? fb_rise  : (dn_q | fb_rise);
      clr_cnt <= (both && !clr) ? clr_cnt + 1'b1 : '0;
      if (clr)
        gap <= '0;
      else if ((up_q ^ dn_q) && gap != '1)
        gap <= gap + 1'b1;
      if (clr)
        hits <= !match ? '0 : (hits == LK_W'(LOCK_N)) ? hits : hits + 1'b1;
    end
  end

  assign pump_up  = up_q & ~dn_q;
  assign pump_dn  = dn_q & ~up_q;
  assign drive_en = pump_up | pump_dn;
  assign phi_r_n  = ~up_q;
  assign phi_v_n  = ~dn_q;
  assign lock     = hits == LK_W'(LOCK_N);

  assert_edge_sets_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !phi_r_n);
  assert_no_edge_no_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_rise && phi_r_n) |=> phi_r_n);
  assert_up_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pump_up |-> (!phi_r_n && phi_v_n && drive_en));
  assert_dn_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pump_dn |-> (!phi_v_n && phi_r_n && drive_en));
  assert_idle_coincide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (phi_r_n == phi_v_n));
  assert_lock_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(clr && match));
  assert_lock_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(clr && !match));
endmodule

// File: tb/pfd_edge_tb_top.sv
module pfd_edge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic pump_up, pump_dn, drive_en, phi_r_n, phi_v_n, lock;

  int total = 0;
  int bad = 0;
  logic meas = 1'b0;
  int n_up, n_dn, n_rlo, n_vlo, n_phimis, n_drvmis;

  always #4 clk = ~clk;

  pfd_edge dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .pump_up(pump_up), .pump_dn(pump_dn), .drive_en(drive_en),
    .phi_r_n(phi_r_n), .phi_v_n(phi_v_n), .lock(lock)
  );

  always @(negedge clk) begin
    if (meas) begin
      n_up     += int'(pump_up);
      n_dn     += int'(pump_dn);
      n_rlo    += int'(!phi_r_n);
      n_vlo    += int'(!phi_v_n);
      n_phimis += int'(phi_r_n != phi_v_n);
      n_drvmis += int'((drive_en != (pump_up | pump_dn)) || (pump_up && pump_dn));
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats();
    n_up = 0; n_dn = 0; n_rlo = 0; n_vlo = 0; n_phimis = 0; n_drvmis = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic run_train(input int per, input int rhi, input int fhi,
                           input int off, input int n);
    for (int k = 0; k < n * per; k++) begin
      int c = k % per;
      int idx = ((c - off) % per + per) % per;
      @(posedge clk); #1;
      ref_in = (c < rhi);
      fb_in  = (idx < fhi);
    end
  endtask

  task automatic measure(input int per, input int rhi, input int fhi,
                         input int off, input int n);
    clear_stats();
    meas = 1'b1;
    run_train(per, rhi, fhi, off, n);
    meas = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ref_in = 1'b1; fb_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 pump_up", int'(pump_up), 0);
    check("R11 pump_dn", int'(pump_dn), 0);
    check("R11 drive_en", int'(drive_en), 0);
    check("R11 phi_r_n", int'(phi_r_n), 1);
    check("R11 phi_v_n", int'(phi_v_n), 1);
    check("R11 lock", int'(lock), 0);
  endtask

  task automatic t_aligned();
    do_reset();
    run_train(20, 10, 10, 0, 3);
    @(negedge clk);
    check("R9 lock low after 3", int'(lock), 0);
    run_train(20, 10, 10, 0, 1);
    @(negedge clk);
    check("R9 lock high after 4", int'(lock), 1);
    measure(20, 10, 10, 0, 4);
    check("R4 pump_up", n_up, 0);
    check("R4 pump_dn", n_dn, 0);
    check("R5 drive mismatch", n_drvmis, 0);
    check("R8 phi_r low", n_rlo, 8);
    check("R8 phi_v low", n_vlo, 8);
    check("R8 phi differ", n_phimis, 0);
  endtask

  task automatic t_lag();
    run_train(20, 10, 10, 3, 2);
    measure(20, 10, 10, 3, 4);
    check("R2 pump_up", n_up, 12);
    check("R2 pump_dn", n_dn, 0);
    check("R7 phi_r low", n_rlo, 20);
    check("R7 phi_v low", n_vlo, 8);
    check("R5 drive mismatch", n_drvmis, 0);
  endtask

  task automatic t_lead();
    run_train(20, 10, 10, -4, 2);
    measure(20, 10, 10, -4, 4);
    check("R3 pump_dn", n_dn, 16);
    check("R3 pump_up", n_up, 0);
    check("R6 phi_v low", n_vlo, 24);
    check("R6 phi_r low", n_rlo, 8);
    check("R5 drive mismatch", n_drvmis, 0);
  endtask

  task automatic t_window_and_drop();
    do_reset();
    run_train(20, 10, 10, 1, 3);
    @(negedge clk);
    check("R9 window lock low after 3", int'(lock), 0);
    run_train(20, 10, 10, 1, 1);
    @(negedge clk);
    check("R9 window lock high after 4", int'(lock), 1);
    measure(20, 10, 10, 1, 2);
    check("R2 one-cycle lag pump_up", n_up, 2);
    run_train(20, 10, 10, 3, 1);
    @(negedge clk);
    check("R10 lock drops on first miss", int'(lock), 0);
  endtask

  task automatic t_duty();
    do_reset();
    run_train(20, 3, 15, 2, 2);
    measure(20, 3, 15, 2, 4);
    check("R1 narrow ref pump_up", n_up, 8);
    run_train(20, 15, 3, 2, 2);
    measure(20, 15, 3, 2, 4);
    check("R1 wide ref pump_up", n_up, 8);
    check("R1 wide ref pump_dn", n_dn, 0);
  endtask

  task automatic t_freq();
    do_reset();
    clear_stats();
    meas = 1'b1;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      ref_in = ((k % 20) < 10);
      fb_in  = ((k % 16) < 8);
    end
    meas = 1'b0;
    total++;
    if (!(n_dn > n_up)) begin
      bad++;
      $display("FAIL R12: actual dn=%0d up=%0d expected dn>up", n_dn, n_up);
    end
    check("R5 drive mismatch fast fb", n_drvmis, 0);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_stats();
    t_reset();
    t_aligned();
    t_lag();
    t_lead();
    t_window_and_drop();
    t_duty();
    t_freq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule